// File: doc/BRIEF.md
# True-Colour DAC Host Register File

This block is the processor-facing register set of a true-colour video DAC. A host reaches it through a single-cycle strobe on an 8-bit bus. Two extra select pins and the two low address bits together pick one of sixteen register slots. The block holds five command bytes, a 10-bit index register that also serves as the cursor-pattern address, and a 1024-byte cursor pattern store. The decoded settings go straight to the video pipeline: DAC width, cursor size and cursor Y offset.

A static type input chooses between two variants, a base part and a revised part. On both, the slot at select code 1010 is shared. While command byte 0 bit 7 is clear, that slot reads back a fixed identity byte. Once that bit is set, the base part treats the slot as command byte 3. The revised part instead uses the low byte of the index register to choose what the slot reaches: command byte 3, command byte 4, or placeholder signature bytes.

Top module: `tcdac_regfile`

## Requirements
- R1: While `rstN` is low, all command bytes, the index register and `rdData` are cleared. After reset, `dacWide` is 0, `cursorLarge` is 0 and `cursorYOff` is 32.
- R2: Select code 0110 reads and writes command byte 0. Its bit 0 drives `dacWide` (1 means 8-bit, 0 means 6-bit).
- R3: Select codes 1000 and 1001 are command bytes 1 and 2. Each is plain 8-bit storage that reads back what was written.
- R4: Select code 0000 is the index port. A write loads index bits 7:0 and clears bits 9:8. A read returns index bits 7:0.
- R5: While command byte 0 bit 7 is clear, a read of code 1010 returns 0x60 on the base variant (`isRevised`=0) and 0x20 on the revised variant. A write there changes no register.
- R6: On the base variant with command byte 0 bit 7 set, code 1010 reads and writes command byte 3, whatever the index holds.
- R7: On the revised variant with command byte 0 bit 7 set, code 1010 is steered by index bits 7:0. Value 0x01 reaches command byte 3 and value 0x02 reaches command byte 4. Any value 0x20 to 0x2F reads 0xFF and ignores writes. Any other value reads 0x00 and ignores writes.
- R8: Command byte 3 bit 2 drives `cursorLarge` (1 means 64x64, 0 means 32x32). `cursorYOff` is 0 in 64x64 mode and 32 in 32x32 mode.
- R9: A write to command byte 3 whose new bit 2 is 1 copies its bits 1:0 into index bits 9:8 and leaves index bits 7:0 unchanged. A write with bit 2 equal to 0 leaves the index unchanged.
- R10: Code 1011 is the cursor data port. A write stores the byte at the current cursor address, and a read returns the stored byte. Each access adds one to the 10-bit index, and 0x3FF wraps to 0x000.
- R11: In 32x32 mode the cursor address is index bits 7:0 only, and bits 9:8 are ignored. In 64x64 mode all 10 bits are used.
- R12: Read data appears on `rdData` in the cycle after the read strobe and holds until the next read. Unmapped select codes read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| isRevised | input | 1 | Variant select, 1 = revised part; change only during reset |
| accStrobe | input | 1 | One-cycle access request |
| accWrite | input | 1 | 1 = write, 0 = read, qualified by accStrobe |
| selExt | input | 2 | Upper two bits of the select code |
| addrLow | input | 2 | Lower two bits of the select code |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| dacWide | output | 1 | 8-bit DAC path enabled |
| cursorLarge | output | 1 | 64x64 cursor mode |
| cursorYOff | output | 6 | Cursor Y offset, 32 or 0 |
| cmd0 | output | 8 | Command byte 0 |
| cmd1 | output | 8 | Command byte 1 |
| cmd2 | output | 8 | Command byte 2 |
| cmd3 | output | 8 | Command byte 3 |
| cmd4 | output | 8 | Command byte 4 |
| curIndex | output | 10 | Index / cursor address register |

## Verification
The command bytes and the index are brought out as ports, so a write that reaches the wrong register shows on the exported value one cycle after the strobe. A wrong decode of slot 1010 shows the same way, as does a missing copy of the upper index bits. A fault in the steering state, such as a wrong variant decision or an index compare, shows on the next read of slot 1010 as the wrong identity or window byte. Cursor-address faults stay hidden until the affected location is read back. The directed tests therefore pair every cursor write with a read that would see an aliased or missed address, in both cursor modes and at the index wrap.

// File: rtl/tcdac_pkg.sv
package tcdac_pkg;

  localparam int DATA_W = 8;
  localparam int IDX_W  = 10;
  localparam int SEL_W  = 4;

  localparam logic [SEL_W-1:0] SEL_INDEX  = 4'b0000;
  localparam logic [SEL_W-1:0] SEL_CMD0   = 4'b0110;
  localparam logic [SEL_W-1:0] SEL_CMD1   = 4'b1000;
  localparam logic [SEL_W-1:0] SEL_CMD2   = 4'b1001;
  localparam logic [SEL_W-1:0] SEL_SHARED = 4'b1010;
  localparam logic [SEL_W-1:0] SEL_CURSOR = 4'b1011;

  localparam logic [DATA_W-1:0] ID_BASE    = 8'h60;
  localparam logic [DATA_W-1:0] ID_REVISED = 8'h20;
  localparam logic [DATA_W-1:0] SIG_FILL   = 8'hFF;

  typedef enum logic [3:0] {
    RD_ZERO,
    RD_INDEX,
    RD_CMD0,
    RD_CMD1,
    RD_CMD2,
    RD_CMD3,
    RD_CMD4,
    RD_ID_BASE,
    RD_ID_REV,
    RD_SIG,
    RD_CURSOR
  } rdSrc_e;

  typedef struct packed {
    logic   wrIndex;
    logic   wrCmd0;
    logic   wrCmd1;
    logic   wrCmd2;
    logic   wrCmd3;
    logic   wrCmd4;
    logic   curWrite;
    logic   curStep;
    logic   rdLoad;
    rdSrc_e rdSrc;
  } ctlStrobe_t;

endpackage

// File: rtl/tcdac_ctrl.sv
module tcdac_ctrl
  import tcdac_pkg::*;
#(
  parameter int SELW = SEL_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            isRevised,
  input  logic            accStrobe,
  input  logic            accWrite,
  input  logic [SELW-1:0] selCode,
  input  logic            extOn,
  input  logic [7:0]      idxLow,
  output ctlStrobe_t      strb
);

  typedef enum logic [2:0] {
    SH_ID,
    SH_CMD3,
    SH_CMD4,
    SH_SIG,
    SH_NONE
  } shTarget_e;

  shTarget_e shTarget;

  // Steering of the shared slot
  always_comb begin
    if (!extOn)                  shTarget = SH_ID;
    else if (!isRevised)         shTarget = SH_CMD3;
    else if (idxLow == 8'h01)    shTarget = SH_CMD3;
    else if (idxLow == 8'h02)    shTarget = SH_CMD4;
    else if (idxLow[7:4] == 4'h2) shTarget = SH_SIG;
    else                         shTarget = SH_NONE;
  end

  always_comb begin
    strb       = '0;
    strb.rdSrc = RD_ZERO;
    if (accStrobe) begin
      strb.rdLoad = !accWrite;
      unique case (selCode)
        SEL_INDEX: begin
          strb.wrIndex = accWrite;
          strb.rdSrc   = RD_INDEX;
        end
        SEL_CMD0: begin
          strb.wrCmd0 = accWrite;
          strb.rdSrc  = RD_CMD0;
        end
        SEL_CMD1: begin
          strb.wrCmd1 = accWrite;
          strb.rdSrc  = RD_CMD1;
        end
        SEL_CMD2: begin
          strb.wrCmd2 = accWrite;
          strb.rdSrc  = RD_CMD2;
        end
        SEL_SHARED: begin
          unique case (shTarget)
            SH_ID:   strb.rdSrc = isRevised ? RD_ID_REV : RD_ID_BASE;
            SH_CMD3: begin
              strb.wrCmd3 = accWrite;
              strb.rdSrc  = RD_CMD3;
            end
            SH_CMD4: begin
              strb.wrCmd4 = accWrite;
              strb.rdSrc  = RD_CMD4;
            end
            SH_SIG:  strb.rdSrc = RD_SIG;
            default: strb.rdSrc = RD_ZERO;
          endcase
        end
        SEL_CURSOR: begin
          strb.curWrite = accWrite;
          strb.curStep  = 1'b1;
          strb.rdSrc    = RD_CURSOR;
        end
        default: strb.rdSrc = RD_ZERO;
      endcase
    end
  end

  // R12: at most one storage target per access
  a_r12_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrIndex, strb.wrCmd0, strb.wrCmd1, strb.wrCmd2,
              strb.wrCmd3, strb.wrCmd4, strb.curWrite}));

  // R7: command byte 4 is reachable on the revised variant only
  a_r7_cmd4_revised: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCmd4 |-> (isRevised && idxLow == 8'h02));

endmodule

// File: rtl/tcdac_datapath.sv
module tcdac_datapath
  import tcdac_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int IW   = IDX_W,
  parameter int SMW  = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strb,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic [DW-1:0] cmd0q,
  output logic [DW-1:0] cmd1q,
  output logic [DW-1:0] cmd2q,
  output logic [DW-1:0] cmd3q,
  output logic [DW-1:0] cmd4q,
  output logic [IW-1:0] idxQ
);

  localparam int CUR_DEPTH = 1 << IW;
  localparam int HI_W      = IW - SMW;

  logic [DW-1:0] curRam [CUR_DEPTH];
  logic [IW-1:0] curEff;
  logic          largeMode;
  logic          armed;

  assign largeMode = cmd3q[2];
  assign curEff    = largeMode ? idxQ : {{HI_W{1'b0}}, idxQ[SMW-1:0]};

  // Command bytes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmd0q <= '0;
      cmd1q <= '0;
      cmd2q <= '0;
      cmd3q <= '0;
      cmd4q <= '0;
    end else begin
      if (strb.wrCmd0) cmd0q <= wrData;
      if (strb.wrCmd1) cmd1q <= wrData;
      if (strb.wrCmd2) cmd2q <= wrData;
      if (strb.wrCmd3) cmd3q <= wrData;
      if (strb.wrCmd4) cmd4q <= wrData;
    end
  end

  // Index / cursor address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (strb.wrIndex) begin
      idxQ <= {{HI_W{1'b0}}, wrData[SMW-1:0]};
    end else if (strb.wrCmd3 && wrData[2]) begin
      idxQ[IW-1:SMW] <= wrData[HI_W-1:0];
    end else if (strb.curStep) begin
      idxQ <= idxQ + 1'b1;
    end
  end

  // Cursor pattern store
  always_ff @(posedge clk) begin
    if (strb.curWrite) curRam[curEff] <= wrData;
  end

  // Registered read path
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdLoad) begin
      unique case (strb.rdSrc)
        RD_INDEX:   rdData <= idxQ[SMW-1:0];
        RD_CMD0:    rdData <= cmd0q;
        RD_CMD1:    rdData <= cmd1q;
        RD_CMD2:    rdData <= cmd2q;
        RD_CMD3:    rdData <= cmd3q;
        RD_CMD4:    rdData <= cmd4q;
        RD_ID_BASE: rdData <= ID_BASE;
        RD_ID_REV:  rdData <= ID_REVISED;
        RD_SIG:     rdData <= SIG_FILL;
        RD_CURSOR:  rdData <= curRam[curEff];
        default:    rdData <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R5: command bytes 3/4 are writable only once the extension bit is set
  a_r5_ext_gate: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCmd3 || strb.wrCmd4) |-> cmd0q[7]);

  // R9: large-mode write to command byte 3 moves only the upper index bits
  a_r9_index_copy: assert property (@(posedge clk) disable iff (!rstN)
    (armed && strb.wrCmd3 && wrData[2]) |=>
      (idxQ[IW-1:SMW] == $past(wrData[HI_W-1:0]) &&
       idxQ[SMW-1:0] == $past(idxQ[SMW-1:0])));

  // R10: cursor access wraps the index from all ones to zero
  a_r10_index_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (armed && strb.curStep && (&idxQ)) |=> (idxQ == '0));

  // R12: read data holds when no read is issued
  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !strb.rdLoad) |=> $stable(rdData));

endmodule

// File: rtl/tcdac_regfile.sv
module tcdac_regfile
  import tcdac_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int IW  = IDX_W,
  parameter int YW  = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          isRevised,
  input  logic          accStrobe,
  input  logic          accWrite,
  input  logic [1:0]    selExt,
  input  logic [1:0]    addrLow,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          dacWide,
  output logic          cursorLarge,
  output logic [YW-1:0] cursorYOff,
  output logic [DW-1:0] cmd0,
  output logic [DW-1:0] cmd1,
  output logic [DW-1:0] cmd2,
  output logic [DW-1:0] cmd3,
  output logic [DW-1:0] cmd4,
  output logic [IW-1:0] curIndex
);

  localparam logic [YW-1:0] SMALL_YOFF = YW'(32);

  ctlStrobe_t strb;

  tcdac_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .isRevised (isRevised),
    .accStrobe (accStrobe),
    .accWrite  (accWrite),
    .selCode   ({selExt, addrLow}),
    .extOn     (cmd0[7]),
    .idxLow    (curIndex[7:0]),
    .strb      (strb)
  );

  tcdac_datapath #(.DW(DW), .IW(IW)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .rdData (rdData),
    .cmd0q  (cmd0),
    .cmd1q  (cmd1),
    .cmd2q  (cmd2),
    .cmd3q  (cmd3),
    .cmd4q  (cmd4),
    .idxQ   (curIndex)
  );

  assign dacWide     = cmd0[0];
  assign cursorLarge = cmd3[2];
  assign cursorYOff  = cursorLarge ? '0 : SMALL_YOFF;

  // R7: the base variant never reaches command byte 4
  a_r7_base_no_cmd4: assert property (@(posedge clk) disable iff (!rstN)
    !isRevised |-> (cmd4 == '0));

endmodule

// File: tb/tcdac_regfile_tb.sv
module tcdac_regfile_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       isRevised = 1'b0;
  logic       accStrobe = 1'b0;
  logic       accWrite = 1'b0;
  logic [1:0] selExt = '0;
  logic [1:0] addrLow = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       dacWide, cursorLarge;
  logic [5:0] cursorYOff;
  logic [7:0] cmd0, cmd1, cmd2, cmd3, cmd4;
  logic [9:0] curIndex;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  tcdac_regfile u_dut (
    .clk(clk), .rstN(rstN), .isRevised(isRevised), .accStrobe(accStrobe),
    .accWrite(accWrite), .selExt(selExt), .addrLow(addrLow), .wrData(wrData),
    .rdData(rdData), .dacWide(dacWide), .cursorLarge(cursorLarge),
    .cursorYOff(cursorYOff), .cmd0(cmd0), .cmd1(cmd1), .cmd2(cmd2),
    .cmd3(cmd3), .cmd4(cmd4), .curIndex(curIndex)
  );

  localparam logic [3:0] S_IDX = 4'b0000, S_C0 = 4'b0110, S_C1 = 4'b1000,
                         S_C2 = 4'b1001, S_SH = 4'b1010, S_CUR = 4'b1011,
                         S_NONE = 4'b0011;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic applyReset(input logic rev);
    @(negedge clk);
    rstN = 1'b0;
    isRevised = rev;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doWrite(input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk);
    {selExt, addrLow} = sel;
    wrData = d;
    accWrite = 1'b1;
    accStrobe = 1'b1;
    @(negedge clk);
    accStrobe = 1'b0;
    accWrite = 1'b0;
  endtask

  task automatic doRead(input logic [3:0] sel, output logic [7:0] d);
    @(negedge clk);
    {selExt, addrLow} = sel;
    accWrite = 1'b0;
    accStrobe = 1'b1;
    @(negedge clk);
    accStrobe = 1'b0;
    d = rdData;
  endtask

  task automatic t_reset;
    doWrite(S_C0, 8'hFF);
    doWrite(S_IDX, 8'h44);
    applyReset(1'b0);
    @(negedge clk);
    check("R1 cmd0", 16'(cmd0), 16'h00);
    check("R1 cmd3", 16'(cmd3), 16'h00);
    check("R1 index", 16'(curIndex), 16'h000);
    check("R1 rdData", 16'(rdData), 16'h00);
    check("R1 dacWide", 16'(dacWide), 16'h0);
    check("R1 yoff", 16'(cursorYOff), 16'd32);
  endtask

  task automatic t_cmd0;
    logic [7:0] d;
    doWrite(S_C0, 8'h01);
    check("R2 dacWide set", 16'(dacWide), 16'h1);
    doRead(S_C0, d);
    check("R2 readback", 16'(d), 16'h01);
    check("R12 hold", 16'(rdData), 16'h01);
    doWrite(S_C0, 8'h00);
    check("R2 dacWide clear", 16'(dacWide), 16'h0);
  endtask

  task automatic t_cmd12;
    logic [7:0] d;
    doWrite(S_C1, 8'hA5);
    doWrite(S_C2, 8'h3C);
    doRead(S_C1, d);
    check("R3 cmd1", 16'(d), 16'hA5);
    doRead(S_C2, d);
    check("R3 cmd2", 16'(d), 16'h3C);
  endtask

  task automatic t_index;
    logic [7:0] d;
    doWrite(S_IDX, 8'h9E);
    check("R4 index", 16'(curIndex), 16'h09E);
    doRead(S_IDX, d);
    check("R4 index read", 16'(d), 16'h9E);
  endtask

  task automatic t_idByte(input logic rev);
    logic [7:0] d;
    applyReset(rev);
    doWrite(S_SH, 8'h77);
    check("R5 cmd3 untouched", 16'(cmd3), 16'h00);
    check("R5 cmd4 untouched", 16'(cmd4), 16'h00);
    doRead(S_SH, d);
    check("R5 id byte", 16'(d), rev ? 16'h20 : 16'h60);
  endtask

  task automatic t_baseCr3;
    logic [7:0] d;
    applyReset(1'b0);
    doWrite(S_C0, 8'h80);
    doWrite(S_IDX, 8'h37);
    doWrite(S_SH, 8'h99);
    check("R6 cmd3 write", 16'(cmd3), 16'h99);
    doRead(S_SH, d);
    check("R6 cmd3 read", 16'(d), 16'h99);
  endtask

  task automatic t_cursorMode;
    // index is 0x37 from t_baseCr3
    doWrite(S_SH, 8'h06);
    check("R8 large", 16'(cursorLarge), 16'h1);
    check("R8 yoff large", 16'(cursorYOff), 16'd0);
    check("R9 copy", 16'(curIndex), 16'h237);
    doWrite(S_SH, 8'h01);
    check("R8 small", 16'(cursorLarge), 16'h0);
    check("R8 yoff small", 16'(cursorYOff), 16'd32);
    check("R9 no copy", 16'(curIndex), 16'h237);
  endtask

  task automatic t_revWindow;
    logic [7:0] d;
    applyReset(1'b1);
    doWrite(S_C0, 8'h80);
    doWrite(S_IDX, 8'h01);
    doWrite(S_SH, 8'h5A);
    check("R7 cmd3 via idx1", 16'(cmd3), 16'h5A);
    doWrite(S_IDX, 8'h02);
    doWrite(S_SH, 8'hC3);
    check("R7 cmd4 via idx2", 16'(cmd4), 16'hC3);
    check("R7 cmd3 kept", 16'(cmd3), 16'h5A);
    doRead(S_SH, d);
    check("R7 cmd4 read", 16'(d), 16'hC3);
    doWrite(S_IDX, 8'h23);
    doWrite(S_SH, 8'h11);
    doRead(S_SH, d);
    check("R7 signature", 16'(d), 16'hFF);
    check("R7 sig write ignored", 16'({cmd3, cmd4}), 16'h5AC3);
    doWrite(S_IDX, 8'h05);
    doWrite(S_SH, 8'h22);
    doRead(S_SH, d);
    check("R7 other idx", 16'(d), 16'h00);
    check("R7 other write ignored", 16'({cmd3, cmd4}), 16'h5AC3);
  endtask

  task automatic t_cursorRam;
    logic [7:0] d;
    applyReset(1'b0);
    doWrite(S_C0, 8'h80);
    // large mode, address 0x105
    doWrite(S_IDX, 8'h05);
    doWrite(S_SH, 8'h05);
    check("R9 idx 105", 16'(curIndex), 16'h105);
    doWrite(S_CUR, 8'hAA);
    check("R10 post-inc", 16'(curIndex), 16'h106);
    doWrite(S_CUR, 8'hAB);
    // small mode, address 0x05 written with a different byte
    doWrite(S_SH, 8'h00);
    doWrite(S_IDX, 8'h05);
    doWrite(S_CUR, 8'hBB);
    // large mode readback at 0x105 and 0x106
    doWrite(S_IDX, 8'h05);
    doWrite(S_SH, 8'h05);
    doRead(S_CUR, d);
    check("R10 read 105", 16'(d), 16'hAA);
    doRead(S_CUR, d);
    check("R10 read 106", 16'(d), 16'hAB);
    check("R10 inc after reads", 16'(curIndex), 16'h107);
    doWrite(S_IDX, 8'h05);
    doWrite(S_SH, 8'h04);
    doRead(S_CUR, d);
    check("R11 large 005", 16'(d), 16'hBB);
    // small mode with upper bits set aliases to low byte
    doWrite(S_IDX, 8'h05);
    doWrite(S_SH, 8'h05);
    doWrite(S_SH, 8'h00);
    check("R11 idx upper kept", 16'(curIndex), 16'h105);
    doRead(S_CUR, d);
    check("R11 small alias", 16'(d), 16'hBB);
    // wrap
    doWrite(S_IDX, 8'hFF);
    doWrite(S_SH, 8'h07);
    check("R10 idx 3ff", 16'(curIndex), 16'h3FF);
    doWrite(S_CUR, 8'h5C);
    check("R10 wrap", 16'(curIndex), 16'h000);
    doWrite(S_IDX, 8'hFF);
    doWrite(S_SH, 8'h07);
    doRead(S_CUR, d);
    check("R10 wrap data", 16'(d), 16'h5C);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    doWrite(S_C1, 8'h4D);
    doWrite(S_NONE, 8'hE7);
    doRead(S_NONE, d);
    check("R12 unmapped read", 16'(d), 16'h00);
    check("R12 unmapped write ignored", 16'({cmd1, cmd2}), 16'h4D00);
  endtask

  initial begin
    applyReset(1'b0);
    t_reset();
    t_cmd0();
    t_cmd12();
    t_index();
    t_idByte(1'b0);
    t_idByte(1'b1);
    t_baseCr3();
    t_cursorMode();
    t_revWindow();
    t_cursorRam();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule